// File: doc/BRIEF.md
# Supervisor Memory Protection Checker

This block holds a small set of protection regions that a supervisor program configures. Each region has an address word and a one-byte attribute field. On each access request it decides whether the physical address may be read, written or fetched, given whether the request comes from user or supervisor mode. It sits behind the machine-level protection stage, so it only sees addresses that stage already let through. A denied request is reported as `rsp_allow = 0` on the cycle after the request. Raising the trap is left to the surrounding core.

Software reaches the storage through a flat register port. `csr_kind` selects attribute words, address words or the enable-switch words, and `csr_idx` selects the word within that group. Attribute bytes are packed several to a word. Writes are legalised as they are stored, and reads are combinational. Region matching is naturally-aligned: either a single 4-byte word, or a power-of-two block encoded by trailing ones in the address word. A fixed granularity parameter sets the smallest block the hardware keeps.

Top module: `smpu_checker`

## Requirements
- R1: After reset every register reads zero, no region is live, supervisor requests are allowed and user requests are denied.
- R2: The attribute byte layout is read bit0, write bit1, exec bit2, mode bits[4:3], user bit6, lock bit7, and bit5 always reads 0. Entry i sits in byte (i mod XLEN/8) of attribute word i/4 when XLEN is 32, and of word 2*(i/8) when XLEN is 64. On a 64-bit build, attribute words 1 and 3 are illegal: `csr_illegal` is 1, they read 0 and writes to them change nothing.
- R3: Mode values are 0 off, 1 range (unsupported), 2 single-word, 3 power-of-two block. A written 1 is stored as 0. A written 2 is stored as 0 when the granularity exponent G is above 2.
- R4: An entry takes part in checking only when its switch bit is 1 and its mode is non-zero.
- R5: In mode 2 an entry covers exactly the 4 bytes at (address word << 2).
- R6: In mode 3, with t trailing ones in the address word, the entry covers 2^(t+3) bytes starting at (address word with its low t bits cleared) << 2.
- R7: When several live entries match, the lowest-numbered one alone decides the outcome.
- R8: The deciding entry grants a request only if its user bit equals the requester's user flag and its read, write or exec bit for the request type (0 read, 1 write, 2 exec) is 1. Supervisor requests that hit a user entry are denied.
- R9: A request that matches no live entry is allowed for supervisor mode and denied for user mode.
- R10: While an entry's lock bit is 1, writes to its attribute byte and its address word are ignored.
- R11: With G above 2, an address word reads back with its low G-3 bits forced to 1 in mode 3, and with its low G-2 bits forced to 0 otherwise. Matching uses the read-back value.
- R12: The enable switch has one bit per entry, and bits at or above the entry count read 0. On a 32-bit build it is switch word 0 (bits 31:0) and word 1 (bits 63:32). On a 64-bit build only word 0 exists, and any other switch index is illegal.
- R13: `rsp_valid` is 1 exactly on the cycle after `req_valid`. `rsp_allow` reflects the register state in the cycle the request was presented.
- R14: An address-word index at or above the entry count is illegal: it reads 0 and writes are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | Register write strobe |
| csr_kind | input | 2 | Register group: 0 attribute, 1 address, 2 switch |
| csr_idx | input | 4 | Word index within the group |
| csr_wdata | input | XLEN | Write data |
| csr_rdata | output | XLEN | Combinational read data for the selected word |
| csr_illegal | output | 1 | The selected word does not exist |
| req_valid | input | 1 | Access check request |
| req_addr | input | XLEN | Physical byte address |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 exec |
| req_user | input | 1 | 1 user mode, 0 supervisor mode |
| rsp_valid | output | 1 | Result present |
| rsp_allow | output | 1 | 1 grant, 0 deny |

## Verification
Most internal faults appear at the ports one cycle after a request, as a flipped `rsp_allow`. Two examples: a corrupted mode or switch bit makes a region vanish, so the request falls to the default outcome, and a wrong priority order lets a later region override an earlier one. Faults in write legalisation, lock handling or granularity forcing show up immediately on the combinational `csr_rdata` of the affected word. A granularity fault can also widen or narrow a region, which a request just past the 8-byte boundary exposes. Every region is exercised at its first and last covered word and at the words just outside it.

// File: rtl/smpu_pkg.sv
package smpu_pkg;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'd0,
        MODE_RANGE = 2'd1,
        MODE_WORD  = 2'd2,
        MODE_BLOCK = 2'd3
    } amode_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2
    } acc_e;

    typedef enum logic [1:0] {
        KIND_ATTR   = 2'd0,
        KIND_ADDR   = 2'd1,
        KIND_SWITCH = 2'd2
    } csr_kind_e;

    // attribute byte, MSB first: lock, user, reserved, mode[1:0], x, w, r
    typedef struct packed {
        logic   lock;
        logic   user;
        logic   rsvd;
        amode_e mode;
        logic   x;
        logic   w;
        logic   r;
    } attr_t;

    typedef struct packed {
        logic user;
        logic x;
        logic w;
        logic r;
    } perm_t;

    function automatic attr_t legal_attr(logic [7:0] raw, logic word_mode_ok);
        attr_t a;
        a      = attr_t'(raw);
        a.rsvd = 1'b0;
        if (a.mode == MODE_RANGE) a.mode = MODE_OFF;
        if (a.mode == MODE_WORD && !word_mode_ok) a.mode = MODE_OFF;
        return a;
    endfunction

    function automatic logic perm_grants(perm_t p, acc_e acc);
        case (acc)
            ACC_READ:  return p.r;
            ACC_WRITE: return p.w;
            ACC_EXEC:  return p.x;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/smpu_csr_file.sv
module smpu_csr_file
    import smpu_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int ENTRIES = 16,
    parameter int GRAN    = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             csr_we,
    input  logic [1:0]       csr_kind,
    input  logic [3:0]       csr_idx,
    input  logic [XLEN-1:0]  csr_wdata,
    output logic [XLEN-1:0]  csr_rdata,
    output logic             csr_illegal,
    output perm_t            perm_o [ENTRIES],
    output amode_e           mode_o [ENTRIES],
    output logic [XLEN-1:0]  eff_addr_o [ENTRIES],
    output logic [ENTRIES-1:0] live_o
);

    localparam int  BYTES_PER_WORD = XLEN / 8;
    localparam bit  WORD_MODE_OK   = (GRAN == 2);
    localparam int  SET_W          = (GRAN > 3) ? GRAN - 3 : 0;
    localparam int  CLR_W          = GRAN - 2;
    localparam logic [XLEN-1:0] SET_MASK = (XLEN'(1) << SET_W) - XLEN'(1);
    localparam logic [XLEN-1:0] CLR_MASK = (XLEN'(1) << CLR_W) - XLEN'(1);

    attr_t              attr_q [ENTRIES];
    logic [XLEN-1:0]    addr_q [ENTRIES];
    logic [ENTRIES-1:0] sw_q;
    logic [63:0]        sw_full;
    logic [63:0]        sw_next;
    logic               legal;
    csr_kind_e          kind;

    function automatic logic [3:0] attr_word_of(int e);
        return (XLEN == 32) ? 4'(e / 4) : 4'((e / 8) * 2);
    endfunction

    assign kind    = csr_kind_e'(csr_kind);
    assign sw_full = 64'(sw_q);

    always_comb begin
        case (kind)
            KIND_ATTR:   legal = (csr_idx < 4'd4) && ((XLEN == 32) || !csr_idx[0]);
            KIND_ADDR:   legal = (32'(csr_idx) < ENTRIES);
            KIND_SWITCH: legal = (XLEN == 32) ? (csr_idx < 4'd2) : (csr_idx == 4'd0);
            default:     legal = 1'b0;
        endcase
    end
    assign csr_illegal = !legal;

    always_comb begin
        sw_next = sw_full;
        if (csr_idx == 4'd0) sw_next[XLEN-1:0] = csr_wdata;
        else                 sw_next[63:32]    = csr_wdata[31:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sw_q <= '0;
        end else if (csr_we && legal && kind == KIND_SWITCH) begin
            sw_q <= sw_next[ENTRIES-1:0];
        end
    end

    for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
        localparam logic [3:0] WORD_IDX = attr_word_of(i);
        localparam int         BYTE_POS = i % BYTES_PER_WORD;

        logic attr_hit;
        logic addr_hit;

        assign attr_hit = csr_we && legal && kind == KIND_ATTR && csr_idx == WORD_IDX;
        assign addr_hit = csr_we && legal && kind == KIND_ADDR && csr_idx == 4'(i);

        always_ff @(posedge clk) begin
            if (rst) begin
                attr_q[i] <= '0;
                addr_q[i] <= '0;
            end else begin
                if (attr_hit && !attr_q[i].lock)
                    attr_q[i] <= legal_attr(csr_wdata[BYTE_POS*8 +: 8], WORD_MODE_OK);
                if (addr_hit && !attr_q[i].lock)
                    addr_q[i] <= csr_wdata;
            end
        end

        assign eff_addr_o[i] = (attr_q[i].mode == MODE_BLOCK) ? (addr_q[i] | SET_MASK)
                                                             : (addr_q[i] & ~CLR_MASK);
        assign mode_o[i] = attr_q[i].mode;
        assign perm_o[i] = '{user: attr_q[i].user, x: attr_q[i].x, w: attr_q[i].w, r: attr_q[i].r};
        assign live_o[i] = sw_q[i] && (attr_q[i].mode != MODE_OFF);

        p_lock_freeze_r10: assert property (@(posedge clk) disable iff (rst)
            attr_q[i].lock |=> $stable(attr_q[i]) && $stable(addr_q[i]))
            else $error("locked entry %0d changed", i);

        p_no_range_mode_r3: assert property (@(posedge clk) disable iff (rst)
            attr_q[i].mode != MODE_RANGE && (WORD_MODE_OK || attr_q[i].mode != MODE_WORD))
            else $error("entry %0d holds an unsupported mode", i);

        p_illegal_write_r2: assert property (@(posedge clk) disable iff (rst)
            csr_we && csr_illegal |=> $stable(attr_q[i]) && $stable(addr_q[i]))
            else $error("illegal write altered entry %0d", i);
    end

    p_illegal_switch_r12: assert property (@(posedge clk) disable iff (rst)
        csr_we && csr_illegal |=> $stable(sw_q))
        else $error("illegal write altered switch");

    always_comb begin
        csr_rdata = '0;
        if (legal) begin
            case (kind)
                KIND_ATTR: begin
                    for (int e = 0; e < ENTRIES; e++) begin
                        if (csr_idx == attr_word_of(e))
                            csr_rdata[(e % BYTES_PER_WORD)*8 +: 8] = attr_q[e];
                    end
                end
                KIND_ADDR: begin
                    for (int e = 0; e < ENTRIES; e++) begin
                        if (csr_idx == 4'(e)) csr_rdata = eff_addr_o[e];
                    end
                end
                KIND_SWITCH: begin
                    if (csr_idx == 4'd0) csr_rdata = sw_full[XLEN-1:0];
                    else                 csr_rdata = XLEN'(sw_full[63:32]);
                end
                default: csr_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/smpu_region_match.sv
module smpu_region_match
    import smpu_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  amode_e           mode,
    input  logic             live,
    input  logic [XLEN-1:0]  eff_addr,
    input  logic [XLEN-1:0]  pa,
    output logic             hit
);

    localparam int WW = XLEN - 2;

    logic [WW-1:0] word;
    logic [WW-1:0] base;
    logic [WW-1:0] care_not;
    logic          word_hit;
    logic          block_hit;
    logic          unused_bits;

    assign word     = pa[XLEN-1:2];
    assign base     = eff_addr[WW-1:0];
    // trailing ones plus the first zero above them mark the don't-care bits
    assign care_not = base ^ (base + WW'(1));

    assign word_hit  = (word == base);
    assign block_hit = (((word ^ base) & ~care_not) == '0);

    always_comb begin
        case (mode)
            MODE_WORD:  hit = live && word_hit;
            MODE_BLOCK: hit = live && block_hit;
            default:    hit = 1'b0;
        endcase
    end

    assign unused_bits = ^{pa[1:0], eff_addr[XLEN-1:WW]};

endmodule

// File: rtl/smpu_priority_resolve.sv
module smpu_priority_resolve
    import smpu_pkg::*;
#(
    parameter int ENTRIES = 16
) (
    input  logic [ENTRIES-1:0] hit,
    input  perm_t              perm [ENTRIES],
    input  acc_e               acc,
    input  logic               user,
    output logic               allow
);

    perm_t win;
    logic  found;

    always_comb begin
        win   = '0;
        found = 1'b0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hit[i]) begin
                win   = perm[i];
                found = 1'b1;
            end
        end
        if (found) allow = (win.user == user) && perm_grants(win, acc);
        else       allow = !user;
    end

endmodule

// File: rtl/smpu_checker.sv
module smpu_checker
    import smpu_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int ENTRIES = 16,
    parameter int GRAN    = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             csr_we,
    input  logic [1:0]       csr_kind,
    input  logic [3:0]       csr_idx,
    input  logic [XLEN-1:0]  csr_wdata,
    output logic [XLEN-1:0]  csr_rdata,
    output logic             csr_illegal,
    input  logic             req_valid,
    input  logic [XLEN-1:0]  req_addr,
    input  logic [1:0]       req_acc,
    input  logic             req_user,
    output logic             rsp_valid,
    output logic             rsp_allow
);

    perm_t              perm_w  [ENTRIES];
    amode_e             mode_w  [ENTRIES];
    logic [XLEN-1:0]    eff_w   [ENTRIES];
    logic [ENTRIES-1:0] live_w;
    logic [ENTRIES-1:0] hit_w;
    logic               allow_w;

    smpu_csr_file #(.XLEN(XLEN), .ENTRIES(ENTRIES), .GRAN(GRAN)) regs_i (
        .clk         (clk),
        .rst         (rst),
        .csr_we      (csr_we),
        .csr_kind    (csr_kind),
        .csr_idx     (csr_idx),
        .csr_wdata   (csr_wdata),
        .csr_rdata   (csr_rdata),
        .csr_illegal (csr_illegal),
        .perm_o      (perm_w),
        .mode_o      (mode_w),
        .eff_addr_o  (eff_w),
        .live_o      (live_w)
    );

    for (genvar i = 0; i < ENTRIES; i++) begin : g_match
        smpu_region_match #(.XLEN(XLEN)) match_i (
            .mode     (mode_w[i]),
            .live     (live_w[i]),
            .eff_addr (eff_w[i]),
            .pa       (req_addr),
            .hit      (hit_w[i])
        );
    end

    smpu_priority_resolve #(.ENTRIES(ENTRIES)) resolve_i (
        .hit   (hit_w),
        .perm  (perm_w),
        .acc   (acc_e'(req_acc)),
        .user  (req_user),
        .allow (allow_w)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_allow <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) rsp_allow <= allow_w;
        end
    end

    p_rsp_follows_r13: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid)
        else $error("response missing");

    p_rsp_quiet_r13: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid)
        else $error("spurious response");

    p_user_default_deny_r9: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_user && (live_w == '0) |=> !rsp_allow)
        else $error("user request allowed with no live region");

    p_sup_default_allow_r9: assert property (@(posedge clk) disable iff (rst)
        req_valid && !req_user && (live_w == '0) |=> rsp_allow)
        else $error("supervisor request denied with no live region");

endmodule

// File: tb/smpu_checker_tb.sv
`timescale 1ns/1ps
module smpu_checker_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #4 clk = ~clk;

    int n_checks = 0;
    int n_err    = 0;

    // 32-bit build, 16 entries, word granularity
    logic        a_we = 0;
    logic [1:0]  a_kind = 0;
    logic [3:0]  a_idx = 0;
    logic [31:0] a_wdata = 0;
    logic [31:0] a_rdata;
    logic        a_ill;
    logic        a_rv = 0;
    logic [31:0] a_addr = 0;
    logic [1:0]  a_acc = 0;
    logic        a_user = 0;
    logic        a_sv;
    logic        a_sa;

    // 64-bit build, 8 entries, 16-byte granularity
    logic        g_we = 0;
    logic [1:0]  g_kind = 0;
    logic [3:0]  g_idx = 0;
    logic [63:0] g_wdata = 0;
    logic [63:0] g_rdata;
    logic        g_ill;
    logic        g_rv = 0;
    logic [63:0] g_addr = 0;
    logic [1:0]  g_acc = 0;
    logic        g_user = 0;
    logic        g_sv;
    logic        g_sa;

    smpu_checker #(.XLEN(32), .ENTRIES(16), .GRAN(2)) dut_i (
        .clk(clk), .rst(rst), .csr_we(a_we), .csr_kind(a_kind), .csr_idx(a_idx),
        .csr_wdata(a_wdata), .csr_rdata(a_rdata), .csr_illegal(a_ill),
        .req_valid(a_rv), .req_addr(a_addr), .req_acc(a_acc), .req_user(a_user),
        .rsp_valid(a_sv), .rsp_allow(a_sa)
    );

    smpu_checker #(.XLEN(64), .ENTRIES(8), .GRAN(4)) dut_g (
        .clk(clk), .rst(rst), .csr_we(g_we), .csr_kind(g_kind), .csr_idx(g_idx),
        .csr_wdata(g_wdata), .csr_rdata(g_rdata), .csr_illegal(g_ill),
        .req_valid(g_rv), .req_addr(g_addr), .req_acc(g_acc), .req_user(g_user),
        .rsp_valid(g_sv), .rsp_allow(g_sa)
    );

    localparam logic [1:0] K_ATTR = 2'd0, K_ADDR = 2'd1, K_SW = 2'd2;
    localparam logic [1:0] RD = 2'd0, WR = 2'd1, EX = 2'd2;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic a_wr(input logic [1:0] k, input logic [3:0] i, input logic [31:0] d);
        @(negedge clk);
        a_kind = k; a_idx = i; a_wdata = d; a_we = 1'b1;
        @(negedge clk);
        a_we = 1'b0;
    endtask

    task automatic a_rd(input logic [1:0] k, input logic [3:0] i,
                        output logic [31:0] d, output logic ill);
        a_kind = k; a_idx = i;
        #1;
        d = a_rdata; ill = a_ill;
    endtask

    task automatic a_req(input logic [31:0] ad, input logic [1:0] t, input logic u,
                         output logic allow);
        @(negedge clk);
        a_addr = ad; a_acc = t; a_user = u; a_rv = 1'b1;
        @(negedge clk);
        a_rv = 1'b0;
        allow = a_sa;
    endtask

    task automatic g_wr(input logic [1:0] k, input logic [3:0] i, input logic [63:0] d);
        @(negedge clk);
        g_kind = k; g_idx = i; g_wdata = d; g_we = 1'b1;
        @(negedge clk);
        g_we = 1'b0;
    endtask

    task automatic g_rd(input logic [1:0] k, input logic [3:0] i,
                        output logic [63:0] d, output logic ill);
        g_kind = k; g_idx = i;
        #1;
        d = g_rdata; ill = g_ill;
    endtask

    task automatic g_req(input logic [63:0] ad, input logic [1:0] t, input logic u,
                         output logic allow);
        @(negedge clk);
        g_addr = ad; g_acc = t; g_user = u; g_rv = 1'b1;
        @(negedge clk);
        g_rv = 1'b0;
        allow = g_sa;
    endtask

    task automatic t_reset;
        logic [31:0] d; logic ill; logic al;
        a_rd(K_ATTR, 4'd0, d, ill);  check("R1 attr0 after reset", d, 0);
        a_rd(K_SW, 4'd0, d, ill);    check("R1 switch after reset", d, 0);
        a_req(32'h1000, RD, 1'b0, al); check("R1 supervisor allowed", al, 1);
        a_req(32'h1000, RD, 1'b1, al); check("R1 user denied", al, 0);
    endtask

    task automatic t_packing;
        logic [31:0] d; logic ill;
        a_wr(K_ATTR, 4'd1, 32'h7F0F1B13);
        a_rd(K_ATTR, 4'd1, d, ill);
        check("R2 R3 attr word1 legalised", d, 32'h5F071B13);
        a_wr(K_ATTR, 4'd1, 32'h0);
        a_rd(K_ATTR, 4'd1, d, ill);
        check("R2 attr word1 cleared", d, 0);
    endtask

    task automatic t_word_mode;
        logic al;
        a_wr(K_ATTR, 4'd0, 32'h0051_0000);
        a_wr(K_ADDR, 4'd2, 32'h400);
        a_req(32'h1000, RD, 1'b1, al); check("R4 switch off keeps entry dead", al, 0);
        a_wr(K_SW, 4'd0, 32'h4);
        a_req(32'h1000, RD, 1'b1, al); check("R5 word hit", al, 1);
        a_req(32'h1004, RD, 1'b1, al); check("R5 next word misses", al, 0);
        a_req(32'h0FFC, RD, 1'b1, al); check("R5 previous word misses", al, 0);
        a_req(32'h1000, WR, 1'b1, al); check("R8 write bit clear", al, 0);
    endtask

    task automatic t_block_mode;
        logic al;
        a_wr(K_ATTR, 4'd0, 32'h5B51_0000);
        a_wr(K_ADDR, 4'd3, 32'h803);
        a_wr(K_SW, 4'd0, 32'hC);
        a_req(32'h201C, RD, 1'b1, al); check("R6 last word in block", al, 1);
        a_req(32'h2000, WR, 1'b1, al); check("R6 first word write", al, 1);
        a_req(32'h2020, RD, 1'b1, al); check("R6 past block end", al, 0);
        a_req(32'h1FFC, RD, 1'b1, al); check("R6 before block", al, 0);
        a_req(32'h2000, EX, 1'b1, al); check("R8 exec bit clear", al, 0);
    endtask

    task automatic t_priority;
        logic al;
        a_wr(K_ATTR, 4'd0, 32'h5B51_5800);
        a_wr(K_ADDR, 4'd1, 32'h800);
        a_wr(K_SW, 4'd0, 32'hE);
        a_req(32'h2004, RD, 1'b1, al); check("R7 lower entry wins", al, 0);
        a_req(32'h2008, RD, 1'b1, al); check("R7 higher entry beyond lower", al, 1);
    endtask

    task automatic t_user_bit;
        logic al;
        a_wr(K_ATTR, 4'd1, 32'h0000_1100);
        a_wr(K_ADDR, 4'd5, 32'hC00);
        a_wr(K_SW, 4'd0, 32'h2E);
        a_req(32'h3000, RD, 1'b0, al); check("R8 supervisor entry for supervisor", al, 1);
        a_req(32'h3000, RD, 1'b1, al); check("R8 supervisor entry denies user", al, 0);
        a_req(32'h201C, RD, 1'b0, al); check("R8 user entry denies supervisor", al, 0);
        a_req(32'h5000, RD, 1'b1, al); check("R9 no match user", al, 0);
        a_req(32'h5000, EX, 1'b0, al); check("R9 no match supervisor", al, 1);
    endtask

    task automatic t_lock;
        logic [31:0] d; logic ill;
        a_wr(K_ADDR, 4'd6, 32'hD00);
        a_wr(K_ATTR, 4'd1, 32'h0091_1100);
        a_wr(K_ADDR, 4'd6, 32'h0);
        a_rd(K_ADDR, 4'd6, d, ill); check("R10 locked address kept", d, 32'hD00);
        a_wr(K_ATTR, 4'd1, 32'h0000_1100);
        a_rd(K_ATTR, 4'd1, d, ill); check("R10 locked attribute kept", d, 32'h0091_1100);
    endtask

    task automatic t_switch;
        logic [31:0] d; logic ill;
        a_rd(K_SW, 4'd0, d, ill); check("R12 switch low word", d, 32'h2E);
        a_wr(K_SW, 4'd1, 32'hFFFF_FFFF);
        a_rd(K_SW, 4'd1, d, ill); check("R12 high bits read zero", d, 0);
        check("R12 high word legal on 32-bit", ill, 0);
        a_rd(K_SW, 4'd2, d, ill); check("R12 switch index 2 illegal", ill, 1);
    endtask

    task automatic t_timing;
        logic al;
        @(negedge clk);
        a_kind = K_SW; a_idx = 4'd0; a_wdata = 32'h0; a_we = 1'b1;
        a_addr = 32'h1000; a_acc = RD; a_user = 1'b1; a_rv = 1'b1;
        @(negedge clk);
        a_we = 1'b0; a_rv = 1'b0;
        check("R13 valid one cycle after request", a_sv, 1);
        check("R13 result uses state at request", a_sa, 1);
        @(negedge clk);
        check("R13 valid drops", a_sv, 0);
        a_req(32'h1000, RD, 1'b1, al); check("R4 switch cleared kills entry", al, 0);
    endtask

    task automatic t_wide_packing;
        logic [63:0] d; logic ill;
        g_wr(K_ATTR, 4'd0, 64'h1300_0000_0000_001B);
        g_rd(K_ATTR, 4'd0, d, ill);
        check("R2 R3 64-bit packing, word mode dropped", d, 64'h0300_0000_0000_001B);
        g_wr(K_ATTR, 4'd1, 64'hFFFF_FFFF_FFFF_FFFF);
        g_rd(K_ATTR, 4'd1, d, ill);
        check("R2 odd attr word illegal", ill, 1);
        check("R2 odd attr word reads zero", d, 0);
        g_rd(K_ATTR, 4'd0, d, ill);
        check("R2 odd write had no effect", d, 64'h0300_0000_0000_001B);
        g_rd(K_SW, 4'd1, d, ill);
        check("R12 64-bit switch index 1 illegal", ill, 1);
        g_rd(K_ADDR, 4'd8, d, ill);
        check("R14 address index beyond entries illegal", ill, 1);
    endtask

    task automatic t_granularity;
        logic [63:0] d; logic ill; logic al;
        g_wr(K_ADDR, 4'd0, 64'h800);
        g_rd(K_ADDR, 4'd0, d, ill); check("R11 block mode low ones", d, 64'h801);
        g_wr(K_SW, 4'd0, 64'h1);
        g_req(64'h2008, EX, 1'b0, al); check("R11 region widened to 16 bytes", al, 0);
        g_req(64'h2008, RD, 1'b0, al); check("R11 read inside region", al, 1);
        g_req(64'h2010, EX, 1'b0, al); check("R11 past 16-byte region", al, 1);
        g_wr(K_ATTR, 4'd0, 64'h03);
        g_wr(K_ADDR, 4'd0, 64'h803);
        g_rd(K_ADDR, 4'd0, d, ill); check("R11 off mode low bits cleared", d, 64'h800);
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    endtask

    initial begin
        #(8 * 200000);
        n_checks++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_packing();
        t_word_mode();
        t_block_mode();
        t_priority();
        t_user_bit();
        t_lock();
        t_switch();
        t_timing();
        t_wide_packing();
        t_granularity();
        finish_run();
    end

endmodule